// File: doc/BRIEF.md
# DMA Controller Global Control and Interrupt Register Block

This block is the shared register file of a multi-channel DMA controller. It holds the controller-wide control word and a per-channel interrupt-pending vector. It also holds a doorbell vector, which tells a channel engine to fetch its next descriptor, and a per-channel clock-enable vector. Software reaches all of it through a simple 32-bit register read/write bus. The channel engines report completion, halt and address-error events to it. It returns one combined interrupt line, one-cycle doorbell pulses and the channel clock enables.

Halt and address-error events from all channels are merged into two sticky flags in the control word. These flags only rise on events. Software clears them with a read-modify-write that writes those two bits as zero. The pending vector clears through an AND-mask write, so writing zero clears every bit. If a channel event and that clear arrive in the same cycle, the event wins, so no completion is lost. The doorbell and clock-enable vectors have write-one-to-set ports, and the clock enables also have a write-one-to-clear port. With these ports, software touching one channel never disturbs the others.

Top module: `dmagc_top`

## Requirements
- R1: After a synchronous active-low reset, every mapped register reads 0, and `irq_o`, `ring_o` and `clk_en_o` are all 0.
- R2: Control register at offset 0x00: bit 0 (controller enable), bit 27 (fast-clear option) and bit 31 (performance option) read back the last value written. All other bits except the two flags read 0.
- R3: Control bit 3 is a sticky halt flag, set by a halt event on any channel. Control bit 2 is a sticky address-error flag, set by an address-error event on any channel. A control write keeps a flag if the written bit is 1 and clears it if the bit is 0. A write never sets a flag.
- R4: Pending register at offset 0x04: bit i is set at the clock edge where channel i reports a done, halt or address-error event. A write to 0x04 leaves pending AND write-data, so writing 0 clears all bits.
- R5: When a channel event and a write clearing the same pending bit fall in the same cycle, the bit ends up set.
- R6: `irq_o` is 1 exactly when control bit 0 is 1 and at least one pending bit is 1.
- R7: Writing 0x0C with bit i set drives `ring_o[i]` high for exactly the one cycle after the write edge. The doorbell register at 0x08 reads that value during that cycle and 0 afterwards. Zero bits of the write, and writes to 0x08, have no effect.
- R8: Clock enables: a write to 0x10 loads the vector directly. A write to 0x14 sets the bits written as 1. A write to 0x18 clears the bits written as 1. All other bits are unchanged.
- R9: Offset 0x1C is a plain read/write channel-mask register of NUM_CH bits.
- R10: Read data is registered and valid in the cycle after `reg_rd_i`. Unmapped offsets, and channel-vector bits at or above NUM_CH, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Byte offset of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid the cycle after a read strobe |
| ev_done_i | input | NUM_CH | Per-channel completion event |
| ev_halt_i | input | NUM_CH | Per-channel halt event |
| ev_aerr_i | input | NUM_CH | Per-channel address-error event |
| irq_o | output | 1 | Combined interrupt request |
| ring_o | output | NUM_CH | Per-channel descriptor-fetch pulse |
| clk_en_o | output | NUM_CH | Per-channel clock enable |

## Verification
The pending logic is tried with a lone completion event, with halt and address-error events on other channels, and with an event that collides with a clearing write in the same cycle. Together these separate plain setting, the flag merge and event priority. Doorbells are rung with a sparse mask, with a mask that only has bits above the channel count, and through the read-only doorbell offset. This tells a true one-cycle pulse from stuck, spurious or mis-decoded pulses. Clock enables go through a direct load, then a set, then a partial clear whose bits overlap the enabled bits. A wrong set/clear mask or a wrong decode shows up as a distinct wrong vector.

// File: rtl/dmagc_pkg.sv
// Shared constants and types for the DMA global control register block.
// Assumes byte offsets on a 32-bit register bus; offsets are decoded exactly.
package dmagc_pkg;
    localparam logic [7:0] OFF_CTRL    = 8'h00;
    localparam logic [7:0] OFF_PEND    = 8'h04;
    localparam logic [7:0] OFF_DBELL   = 8'h08;
    localparam logic [7:0] OFF_DBSET   = 8'h0C;
    localparam logic [7:0] OFF_CKE     = 8'h10;
    localparam logic [7:0] OFF_CKESET  = 8'h14;
    localparam logic [7:0] OFF_CKECLR  = 8'h18;
    localparam logic [7:0] OFF_MASK    = 8'h1C;

    localparam int CTL_EN_BIT      = 0;
    localparam int CTL_AERR_BIT    = 2;
    localparam int CTL_HALT_BIT    = 3;
    localparam int CTL_FASTCLR_BIT = 27;
    localparam int CTL_PERF_BIT    = 31;

    typedef struct packed {
        logic ctrl;
        logic pend;
        logic db_set;
        logic cke_load;
        logic cke_set;
        logic cke_clr;
        logic mask;
    } wr_strobe_t;
endpackage

// File: rtl/dmagc_decode.sv
// Write decoder: turns a bus write into one strobe per writable register.
// Assumes at most one write per cycle; unmapped offsets and 0x08 give no strobe.
module dmagc_decode
    import dmagc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    output wr_strobe_t        stb_o
);
    // Compare the offset against each writable register.
    always_comb begin
        stb_o          = '0;
        stb_o.ctrl     = wr_i && (addr_i == ADDR_W'(OFF_CTRL));
        stb_o.pend     = wr_i && (addr_i == ADDR_W'(OFF_PEND));
        stb_o.db_set   = wr_i && (addr_i == ADDR_W'(OFF_DBSET));
        stb_o.cke_load = wr_i && (addr_i == ADDR_W'(OFF_CKE));
        stb_o.cke_set  = wr_i && (addr_i == ADDR_W'(OFF_CKESET));
        stb_o.cke_clr  = wr_i && (addr_i == ADDR_W'(OFF_CKECLR));
        stb_o.mask     = wr_i && (addr_i == ADDR_W'(OFF_MASK));
    end
endmodule

// File: rtl/dmagc_irq_bank.sv
// Interrupt bank: per-channel pending bits, merged sticky halt/address-error
// flags and the combined interrupt line. Assumes events are single-cycle or
// level; any cycle with an event sets the bit. Events beat software clears.
module dmagc_irq_bank
    import dmagc_pkg::*;
#(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ev_done_i,
    input  logic [NUM_CH-1:0] ev_halt_i,
    input  logic [NUM_CH-1:0] ev_aerr_i,
    input  logic              pend_wr_i,
    input  logic              ctrl_wr_i,
    input  logic [31:0]       wdata_i,
    input  logic              enable_i,
    output logic [NUM_CH-1:0] pend_o,
    output logic              halt_flag_o,
    output logic              aerr_flag_o,
    output logic              irq_o
);
    logic [NUM_CH-1:0] ev_any;
    logic [NUM_CH-1:0] pend_kept;
    logic              halt_kept;
    logic              aerr_kept;

    // Any reported event on a channel raises its pending bit.
    assign ev_any = ev_done_i | ev_halt_i | ev_aerr_i;

    // What survives a software write, before new events are merged in.
    always_comb begin
        pend_kept = pend_wr_i ? (pend_o & wdata_i[NUM_CH-1:0]) : pend_o;
        halt_kept = ctrl_wr_i ? (halt_flag_o & wdata_i[CTL_HALT_BIT]) : halt_flag_o;
        aerr_kept = ctrl_wr_i ? (aerr_flag_o & wdata_i[CTL_AERR_BIT]) : aerr_flag_o;
    end

    // Pending vector and sticky flags; events are ORed last so they win.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_o      <= '0;
            halt_flag_o <= 1'b0;
            aerr_flag_o <= 1'b0;
        end else begin
            pend_o      <= pend_kept | ev_any;
            halt_flag_o <= halt_kept | (|ev_halt_i);
            aerr_flag_o <= aerr_kept | (|ev_aerr_i);
        end
    end

    // Interrupt request: any pending channel while the controller is enabled.
    assign irq_o = enable_i && (|pend_o);

    // R4 R5
    pend_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_any) |=> ((pend_o & $past(ev_any)) == $past(ev_any)));

    // R3
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_halt_i) |=> halt_flag_o);

    // R3
    aerr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aerr_flag_o) |-> $past(|ev_aerr_i));
endmodule

// File: rtl/dmagc_chan_bits.sv
// Per-channel doorbell pulses and clock enables. A doorbell bit lives for
// exactly one cycle; clock enables support load, set-ones and clear-ones.
// Assumes the decoder raises at most one strobe per cycle.
module dmagc_chan_bits #(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              db_set_i,
    input  logic              cke_load_i,
    input  logic              cke_set_i,
    input  logic              cke_clr_i,
    input  logic [31:0]       wdata_i,
    output logic [NUM_CH-1:0] ring_o,
    output logic [NUM_CH-1:0] cke_o
);
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        // Doorbell: high for one cycle after a set write with this bit as one.
        always_ff @(posedge clk) begin
            if (!rst_n) ring_o[ch] <= 1'b0;
            else        ring_o[ch] <= db_set_i && wdata_i[ch];
        end

        // Clock enable: direct load, or set/clear by ones in the write data.
        always_ff @(posedge clk) begin
            if (!rst_n)                        cke_o[ch] <= 1'b0;
            else if (cke_load_i)               cke_o[ch] <= wdata_i[ch];
            else if (cke_set_i && wdata_i[ch]) cke_o[ch] <= 1'b1;
            else if (cke_clr_i && wdata_i[ch]) cke_o[ch] <= 1'b0;
        end
    end

    // R7
    ring_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ring_o) && !db_set_i) |=> (ring_o == '0));

    // R8
    cke_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cke_set_i |=> ((cke_o & $past(wdata_i[NUM_CH-1:0])) == $past(wdata_i[NUM_CH-1:0])));

    // R8
    cke_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cke_clr_i |=> ((cke_o & $past(wdata_i[NUM_CH-1:0])) == '0));
endmodule

// File: rtl/dmagc_top.sv
// DMA global control and interrupt register block. Holds the control word,
// the channel-mask register and the registered read path; pending bits,
// flags, doorbells and clock enables live in submodules.
// Assumes 1 <= NUM_CH <= 32 (6 and 32 are the intended configurations).
module dmagc_top
    import dmagc_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    input  logic [NUM_CH-1:0] ev_done_i,
    input  logic [NUM_CH-1:0] ev_halt_i,
    input  logic [NUM_CH-1:0] ev_aerr_i,
    output logic              irq_o,
    output logic [NUM_CH-1:0] ring_o,
    output logic [NUM_CH-1:0] clk_en_o
);
    wr_strobe_t        stb;
    logic              ctl_en, ctl_fastclr, ctl_perf;
    logic              halt_flag, aerr_flag;
    logic [NUM_CH-1:0] pend;
    logic [NUM_CH-1:0] chan_mask;
    logic [31:0]       ctrl_word;
    logic [31:0]       rd_mux;

    dmagc_decode #(.ADDR_W(ADDR_W)) u_decode (
        .wr_i   (reg_wr_i),
        .addr_i (reg_addr_i),
        .stb_o  (stb)
    );

    dmagc_irq_bank #(.NUM_CH(NUM_CH)) u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_done_i   (ev_done_i),
        .ev_halt_i   (ev_halt_i),
        .ev_aerr_i   (ev_aerr_i),
        .pend_wr_i   (stb.pend),
        .ctrl_wr_i   (stb.ctrl),
        .wdata_i     (reg_wdata_i),
        .enable_i    (ctl_en),
        .pend_o      (pend),
        .halt_flag_o (halt_flag),
        .aerr_flag_o (aerr_flag),
        .irq_o       (irq_o)
    );

    dmagc_chan_bits #(.NUM_CH(NUM_CH)) u_chan (
        .clk        (clk),
        .rst_n      (rst_n),
        .db_set_i   (stb.db_set),
        .cke_load_i (stb.cke_load),
        .cke_set_i  (stb.cke_set),
        .cke_clr_i  (stb.cke_clr),
        .wdata_i    (reg_wdata_i),
        .ring_o     (ring_o),
        .cke_o      (clk_en_o)
    );

    // Control option bits: plain storage, written by a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_en      <= 1'b0;
            ctl_fastclr <= 1'b0;
            ctl_perf    <= 1'b0;
        end else if (stb.ctrl) begin
            ctl_en      <= reg_wdata_i[CTL_EN_BIT];
            ctl_fastclr <= reg_wdata_i[CTL_FASTCLR_BIT];
            ctl_perf    <= reg_wdata_i[CTL_PERF_BIT];
        end
    end

    // Channel-mask register: plain storage of NUM_CH bits.
    always_ff @(posedge clk) begin
        if (!rst_n)        chan_mask <= '0;
        else if (stb.mask) chan_mask <= reg_wdata_i[NUM_CH-1:0];
    end

    // Assemble the control word from options and sticky flags.
    always_comb begin
        ctrl_word                  = '0;
        ctrl_word[CTL_EN_BIT]      = ctl_en;
        ctrl_word[CTL_AERR_BIT]    = aerr_flag;
        ctrl_word[CTL_HALT_BIT]    = halt_flag;
        ctrl_word[CTL_FASTCLR_BIT] = ctl_fastclr;
        ctrl_word[CTL_PERF_BIT]    = ctl_perf;
    end

    // Select read data by offset; unmapped and write-only ports read 0.
    always_comb begin
        if      (reg_addr_i == ADDR_W'(OFF_CTRL))  rd_mux = ctrl_word;
        else if (reg_addr_i == ADDR_W'(OFF_PEND))  rd_mux = 32'(pend);
        else if (reg_addr_i == ADDR_W'(OFF_DBELL)) rd_mux = 32'(ring_o);
        else if (reg_addr_i == ADDR_W'(OFF_CKE))   rd_mux = 32'(clk_en_o);
        else if (reg_addr_i == ADDR_W'(OFF_MASK))  rd_mux = 32'(chan_mask);
        else                                       rd_mux = '0;
    end

    // Registered read port: data valid the cycle after the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        reg_rdata_o <= '0;
        else if (reg_rd_i) reg_rdata_o <= rd_mux;
    end

    // R6
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb.ctrl && !reg_wdata_i[CTL_EN_BIT]) |=> !irq_o);
endmodule

// File: tb/dmagc_top_bench.sv
// Scoreboard bench: read tasks queue expected data, a monitor compares.
module dmagc_top_bench;
    localparam int N = 6;
    localparam logic [N-1:0] ALL = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr = 1'b0, rd = 1'b0;
    logic [7:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [N-1:0] ev_done = '0, ev_halt = '0, ev_aerr = '0;
    logic irq;
    logic [N-1:0] ring, cke;

    int n_tests = 0;
    int n_fail = 0;
    logic [31:0] exp_q[$];
    string tag_q[$];
    logic rd_seen = 1'b0;

    always #2.5 clk = ~clk;

    dmagc_top #(.NUM_CH(N), .ADDR_W(8)) u_dmagc_top (
        .clk(clk), .rst_n(rst_n), .reg_wr_i(wr), .reg_rd_i(rd),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .ev_done_i(ev_done), .ev_halt_i(ev_halt), .ev_aerr_i(ev_aerr),
        .irq_o(irq), .ring_o(ring), .clk_en_o(cke)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: the cycle after a read strobe, pop and compare.
    always @(posedge clk) rd_seen <= rd;
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, rdata, e);
        end
    end

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic reg_read(input logic [7:0] a, input logic [31:0] e, input string tag);
        rd = 1'b1; addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic pulse_ev(input logic [N-1:0] d, input logic [N-1:0] h, input logic [N-1:0] x);
        ev_done = d; ev_halt = h; ev_aerr = x;
        @(negedge clk);
        ev_done = '0; ev_halt = '0; ev_aerr = '0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 irq", 32'(irq), 0);
        check("R1 ring", 32'(ring), 0);
        check("R1 clk_en", 32'(cke), 0);
        for (int a = 0; a < 8; a++) reg_read(8'(a * 4), 0, "R1 reg");

        // R2 options read back; R3 write never sets flags
        reg_write(8'h00, 32'hFFFF_FFFF);
        reg_read(8'h00, 32'h8800_0001, "R2 R3 ctrl readback");

        // R4 done event sets pending; R6 irq with enable
        pulse_ev(6'b000100, '0, '0);
        check("R6 irq set", 32'(irq), 1);
        reg_read(8'h04, 32'h4, "R4 pending bit2");
        // R6 disable gates irq
        reg_write(8'h00, 32'h0);
        check("R6 irq gated", 32'(irq), 0);
        reg_write(8'h00, 32'h1);
        check("R6 irq re-enabled", 32'(irq), 1);
        // R4 write 0 clears pending
        reg_write(8'h04, 32'h0);
        check("R4 irq after clear", 32'(irq), 0);
        reg_read(8'h04, 32'h0, "R4 pending cleared");

        // R5 event beats same-cycle clear
        ev_done = 6'b100000; wr = 1'b1; addr = 8'h04; wdata = '0;
        @(negedge clk);
        ev_done = '0; wr = 1'b0;
        reg_read(8'h04, 32'h20, "R5 event wins");
        reg_write(8'h04, 32'h0);

        // R3 halt and address-error flags, R4 from those events
        pulse_ev('0, 6'b000010, 6'b010000);
        reg_read(8'h04, 32'h12, "R4 halt/aerr pending");
        reg_read(8'h00, 32'h0000_000D, "R3 flags set");
        reg_write(8'h00, 32'h0000_000D);
        reg_read(8'h00, 32'h0000_000D, "R3 write ones keeps flags");
        reg_write(8'h00, 32'h0000_0001);
        reg_read(8'h00, 32'h0000_0001, "R3 write zero clears flags");
        reg_write(8'h04, 32'h0);

        // R7 doorbell pulse and readback
        reg_write(8'h0C, 32'h0000_0025);
        check("R7 ring pulse", 32'(ring), 32'h25);
        reg_read(8'h08, 32'h25, "R7 doorbell read during pulse");
        check("R7 ring self-clear", 32'(ring), 0);
        reg_read(8'h08, 32'h0, "R7 doorbell read after");
        reg_write(8'h0C, 32'hFFFF_FFC0);
        check("R7 zero bits no effect", 32'(ring), 0);
        reg_write(8'h08, 32'hFFFF_FFFF);
        check("R7 write to 0x08 ignored", 32'(ring), 0);

        // R8 clock enables
        reg_write(8'h10, 32'h0F);
        check("R8 load", 32'(cke), 32'h0F);
        reg_write(8'h14, 32'h30);
        check("R8 set", 32'(cke), 32'h3F);
        reg_write(8'h18, 32'h05);
        check("R8 clear", 32'(cke), 32'h3A);
        reg_read(8'h10, 32'h3A, "R8 readback");

        // R9 mask, R10 width limit and unmapped offsets
        reg_write(8'h1C, 32'hFFFF_FFFF);
        reg_read(8'h1C, 32'(ALL), "R9 R10 mask");
        reg_write(8'h1C, 32'h0000_0012);
        reg_read(8'h1C, 32'h12, "R9 mask pattern");
        reg_read(8'h20, 32'h0, "R10 unmapped 0x20");
        reg_read(8'h02, 32'h0, "R10 misaligned");
        reg_read(8'h14, 32'h0, "R10 set port reads 0");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_tests++; n_fail++;
            $display("FAIL R10: actual %0d reads unanswered expected 0", exp_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule